// File: doc/BRIEF.md
# Dual Phase Detector with Lock Monitor

This block compares a reference strobe against the feedback strobes of two frequency-synthesis loops, one for the transmit path and one for the receive path. For each loop it produces a three-state correction drive, modelled as an output enable plus a level. The drive pushes up while the reference edge is ahead of the divider edge and pushes down while the divider edge is ahead. It releases to high impedance once both edges of a pair have been seen. All strobes are single-cycle pulses synchronous to the crystal clock.

The block also holds a shared lock monitor. Each lane counts the crystal-clock cycles between the first and second edge of a pair. When the gap exceeds the error window (64 cycles, which is 6.25 us at 10.24 MHz), that lane reports a fault. Any fault turns on the unlock indication. The indication stays on until a full hold period of reference strobes (32, which is 6.4 ms at a 5 kHz reference) has passed with no new fault. While the loops are locked, the unlock pin floats. A standby input turns off the transmit lane, and that lane then contributes nothing.

Top module: `dual_pfd_lockmon`

## Requirements
- R1: When a lane sees the reference strobe before its divider strobe, the lane's drive is enabled with level 1 (pushing up) from the next cycle until the divider strobe is sampled.
- R2: When a lane sees the divider strobe before the reference strobe, the lane's drive is enabled with level 0 (pushing down) from the next cycle until the reference strobe is sampled.
- R3: The cycle after the second edge of a pair is sampled, the drive is disabled. If both strobes arrive in the same cycle, the drive is never enabled. Whenever the drive is disabled, its level reads 0.
- R4: A pair whose edges are at most 64 cycles apart raises no fault. If 64 cycles pass after the first edge and the second edge has still not been sampled, a fault is raised. This also covers a divider strobe that never arrives.
- R5: The unlock output is floating (enable 0, level 0) after reset and while no fault has occurred. Two cycles after the clock edge that closes a 64-cycle gap with no second edge, the unlock output is driven (enable 1, level 1).
- R6: Once driven, the unlock output is released in the cycle after the 32nd reference strobe that follows the last fault.
- R7: A new fault while the unlock output is driven restarts the 32-strobe hold.
- R8: A fault in either the transmit lane or the receive lane drives the shared unlock output.
- R9: While the transmit enable is 0, the transmit drive is disabled, the transmit lane's pending edges are discarded, and the transmit lane raises no fault. The receive lane is not affected.
- R10: After reset, all three outputs are disabled and read level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Reference strobe, one cycle per reference period |
| tx_en | input | 1 | Transmit lane enable; 0 = standby |
| tx_div_stb | input | 1 | Transmit divider strobe |
| rx_div_stb | input | 1 | Receive divider strobe |
| tx_pd_oe | output | 1 | Transmit correction drive enable |
| tx_pd_lvl | output | 1 | Transmit correction level (1 up, 0 down) |
| rx_pd_oe | output | 1 | Receive correction drive enable |
| rx_pd_lvl | output | 1 | Receive correction level (1 up, 0 down) |
| unlk_oe | output | 1 | Unlock indication drive enable; 0 = floating |
| unlk_lvl | output | 1 | Unlock indication level |

## Verification
If a lane's edge-tracking state is wrong, the correction drive has the wrong enable or polarity on the very next cycle. That makes a per-cycle comparison of both drives the fastest way to expose it. A wrong gap count shows only at the window boundary: at exactly 64 cycles the unlock output must stay floating, and at 65 it must come on two cycles after the 64-cycle mark. A wrong hold count shows 32 reference periods later as an early or late release, and only a sweep of retriggered faults separates the two cases.

// File: rtl/pll_mon_pkg.sv
package pll_mon_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_TX   = 0;
  localparam int LANE_RX   = 1;

  typedef struct packed {
    logic oe;
    logic lvl;
  } drive_t;
endpackage

// File: rtl/pfd_lane.sv
module pfd_lane #(
  parameter int WIN_CYC = 64,
  localparam int CNT_W = $clog2(WIN_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ref_p,
  input  logic div_p,
  output pll_mon_pkg::drive_t pd,
  output logic flt
);
  localparam logic [CNT_W-1:0] CNT_WIN = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WIN_CYC + 1);

  logic ref_seen, div_seen, flt_q;
  logic [CNT_W-1:0] gap_cnt;
  logic nxt_ref, nxt_div, pending, pair_done, starting, late;

  always_comb begin
    nxt_ref   = ref_seen | ref_p;
    nxt_div   = div_seen | div_p;
    pending   = ref_seen ^ div_seen;
    pair_done = nxt_ref & nxt_div;
    starting  = !ref_seen && !div_seen && (ref_p ^ div_p);
    late      = pending && !pair_done && (gap_cnt == CNT_WIN);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ref_seen <= 1'b0;
      div_seen <= 1'b0;
      gap_cnt  <= '0;
      flt_q    <= 1'b0;
    end else begin
      flt_q <= late;
      if (pair_done) begin
        ref_seen <= 1'b0;
        div_seen <= 1'b0;
        gap_cnt  <= '0;
      end else begin
        ref_seen <= nxt_ref;
        div_seen <= nxt_div;
        if (starting)
          gap_cnt <= CNT_W'(1);
        else if (pending && gap_cnt != CNT_SAT)
          gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  assign pd.oe  = ref_seen | div_seen;
  assign pd.lvl = ref_seen;
  assign flt    = flt_q;

  p_ref_lead_r1: assert property (@(posedge clk) disable iff (rst)
    (en && ref_p && !div_p && !pd.oe) |=> (pd.oe && pd.lvl));
  p_div_lead_r2: assert property (@(posedge clk) disable iff (rst)
    (en && div_p && !ref_p && !pd.oe) |=> (pd.oe && !pd.lvl));
  p_pair_release_r3: assert property (@(posedge clk) disable iff (rst)
    (pd.oe && pd.lvl && div_p) |=> !pd.oe);
  p_hiz_level_r3: assert property (@(posedge clk) disable iff (rst)
    !pd.oe |-> !pd.lvl);
  p_fault_needs_pending_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flt) |-> $past(pd.oe));
  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pd.oe && !flt));
endmodule

// File: rtl/unlock_hold.sv
module unlock_hold #(
  parameter int HOLD_REFS = 32,
  localparam int HOLD_W = $clog2(HOLD_REFS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flt_any,
  input  logic ref_p,
  output logic unlk_oe,
  output logic unlk_lvl
);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_REFS);

  logic active;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      hold_cnt <= '0;
    end else if (flt_any) begin
      active   <= 1'b1;
      hold_cnt <= HOLD_LOAD;
    end else if (active && ref_p) begin
      if (hold_cnt == HOLD_W'(1)) begin
        active   <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  assign unlk_oe  = active;
  assign unlk_lvl = active;

  p_fault_sets_r5: assert property (@(posedge clk) disable iff (rst)
    flt_any |=> unlk_oe);
  p_float_level_r5: assert property (@(posedge clk) disable iff (rst)
    unlk_oe == unlk_lvl);
  p_release_on_ref_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(unlk_oe) |-> ($past(ref_p) && !$past(flt_any)));
endmodule

// File: rtl/dual_pfd_lockmon.sv
module dual_pfd_lockmon #(
  parameter int WIN_CYC   = 64,
  parameter int HOLD_REFS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_stb,
  input  logic tx_en,
  input  logic tx_div_stb,
  input  logic rx_div_stb,
  output logic tx_pd_oe,
  output logic tx_pd_lvl,
  output logic rx_pd_oe,
  output logic rx_pd_lvl,
  output logic unlk_oe,
  output logic unlk_lvl
);
  import pll_mon_pkg::*;

  logic   [NUM_LANES-1:0] lane_en;
  logic   [NUM_LANES-1:0] lane_div;
  logic   [NUM_LANES-1:0] lane_flt;
  drive_t                 lane_pd [NUM_LANES];

  assign lane_en[LANE_TX]  = tx_en;
  assign lane_en[LANE_RX]  = 1'b1;
  assign lane_div[LANE_TX] = tx_div_stb;
  assign lane_div[LANE_RX] = rx_div_stb;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pfd_lane #(.WIN_CYC(WIN_CYC)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (lane_en[g]),
      .ref_p(ref_stb),
      .div_p(lane_div[g]),
      .pd   (lane_pd[g]),
      .flt  (lane_flt[g])
    );
  end

  unlock_hold #(.HOLD_REFS(HOLD_REFS)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .flt_any (|lane_flt),
    .ref_p   (ref_stb),
    .unlk_oe (unlk_oe),
    .unlk_lvl(unlk_lvl)
  );

  assign tx_pd_oe  = lane_pd[LANE_TX].oe;
  assign tx_pd_lvl = lane_pd[LANE_TX].lvl;
  assign rx_pd_oe  = lane_pd[LANE_RX].oe;
  assign rx_pd_lvl = lane_pd[LANE_RX].lvl;

  p_either_lane_r8: assert property (@(posedge clk) disable iff (rst)
    (lane_flt[LANE_TX] || lane_flt[LANE_RX]) |=> unlk_oe);
  p_rx_free_of_standby_r9: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_pd_oe && ref_stb && !rx_div_stb) |=> (rx_pd_oe && rx_pd_lvl));
endmodule

// File: tb/dual_pfd_lockmon_test.sv
module dual_pfd_lockmon_test;
  localparam int WIN    = 64;
  localparam int HOLD   = 32;
  localparam int PERIOD = 200;
  localparam int REF_AT = 80;
  localparam int NONE   = 999;

  logic clk = 1'b0;
  logic rst, ref_stb, tx_en, tx_div_stb, rx_div_stb;
  logic tx_pd_oe, tx_pd_lvl, rx_pd_oe, rx_pd_lvl, unlk_oe, unlk_lvl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int fail_prints = 0;

  always #4 clk = ~clk;

  dual_pfd_lockmon #(.WIN_CYC(WIN), .HOLD_REFS(HOLD)) uut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .tx_en(tx_en),
    .tx_div_stb(tx_div_stb), .rx_div_stb(rx_div_stb),
    .tx_pd_oe(tx_pd_oe), .tx_pd_lvl(tx_pd_lvl),
    .rx_pd_oe(rx_pd_oe), .rx_pd_lvl(rx_pd_lvl),
    .unlk_oe(unlk_oe), .unlk_lvl(unlk_lvl)
  );

  // bench model of each lane: seen-reference, seen-divider, gap, fault flag
  bit m_r [2];
  bit m_d [2];
  int m_g [2];
  bit m_f [2];
  bit m_act;
  int m_hold;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      if (fail_prints < 40) begin
        fail_prints++;
        $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
      end
    end
  endtask

  function automatic string drive_tag(input bit oe, input bit lvl);
    if (!oe) return "R3";
    return lvl ? "R1" : "R2";
  endfunction

  task automatic model_edge(input bit rp, input bit en, input bit tp, input bit dp);
    bit fo [2];
    bit dv [2];
    bit le [2];
    fo[0] = m_f[0]; fo[1] = m_f[1];
    dv[0] = tp; dv[1] = dp;
    le[0] = en; le[1] = 1'b1;
    // monitor uses fault flags from before this edge
    if (fo[0] || fo[1]) begin
      m_act = 1'b1; m_hold = HOLD;
    end else if (m_act && rp) begin
      m_hold--;
      if (m_hold == 0) m_act = 1'b0;
    end
    for (int k = 0; k < 2; k++) begin
      if (!le[k]) begin
        m_r[k] = 0; m_d[k] = 0; m_g[k] = 0; m_f[k] = 0;
      end else begin
        bit was_pend, gets_r, gets_d;
        was_pend = m_r[k] ^ m_d[k];
        gets_r = m_r[k] | rp;
        gets_d = m_d[k] | dv[k];
        m_f[k] = was_pend && !(gets_r && gets_d) && (m_g[k] == WIN);
        if (gets_r && gets_d) begin
          m_r[k] = 0; m_d[k] = 0; m_g[k] = 0;
        end else if (!was_pend && (gets_r || gets_d)) begin
          m_r[k] = gets_r; m_d[k] = gets_d; m_g[k] = 1;
        end else if (was_pend && m_g[k] <= WIN) begin
          m_g[k]++;
        end
      end
    end
  endtask

  task automatic step(input bit rp, input bit en, input bit tp, input bit dp);
    ref_stb = rp; tx_en = en; tx_div_stb = tp; rx_div_stb = dp;
    @(posedge clk);
    model_edge(rp, en, tp, dp);
    @(negedge clk);
    cycles++;
    check(en ? drive_tag(m_r[0], m_r[0]) : "R9", {tx_pd_oe, tx_pd_lvl}, {m_r[0] | m_d[0], m_r[0]}, "tx drive");
    check(drive_tag(m_r[1], m_r[1]), {rx_pd_oe, rx_pd_lvl}, {m_r[1] | m_d[1], m_r[1]}, "rx drive");
    check(m_act ? "R6" : "R5", {unlk_oe, unlk_lvl}, {m_act, m_act}, "unlock");
  endtask

  task automatic period(input int otx, input int orx, input bit en);
    for (int c = 0; c < PERIOD; c++)
      step(c == REF_AT, en, c == REF_AT + otx, c == REF_AT + orx);
  endtask

  function automatic int rand_off();
    int sel;
    sel = $urandom_range(0, 9);
    if (sel == 0) return NONE;
    if (sel < 3) return 60 + $urandom_range(0, 10);
    return $urandom_range(0, 140) - 70;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; ref_stb = 0; tx_en = 1; tx_div_stb = 0; rx_div_stb = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", {tx_pd_oe, tx_pd_lvl, rx_pd_oe, rx_pd_lvl, unlk_oe, unlk_lvl}, 0, "outputs after reset");

    period(0, 0, 1);                       // same-cycle pair: R3
    period(5, -5, 1);                      // ref leads tx (R1), div leads rx (R2)
    period(WIN, -WIN, 1);                  // exactly at the window: R4
    check("R4", unlk_oe, 0, "no unlock at 64-cycle gap");

    period(WIN + 1, 0, 1);                 // tx one beyond window
    check("R4", unlk_oe, 1, "unlock at 65-cycle gap");
    check("R8", unlk_lvl, 1, "tx lane drives shared unlock");
    for (int p = 0; p < HOLD - 1; p++) period(3, 3, 1);
    check("R6", unlk_oe, 1, "still held after 31 clean strobes");
    period(3, 3, 1);
    check("R6", unlk_oe, 0, "released after 32 clean strobes");

    period(0, -(WIN + 6), 1);              // rx divider leads by 70
    check("R8", unlk_oe, 1, "rx lane drives shared unlock");
    for (int p = 0; p < 20; p++) period(2, 2, 1);
    period(2, NONE, 1);                    // rx divider missing: R4
    check("R4", unlk_oe, 1, "missing divider strobe faults");
    period(2, 2, 1);                       // closes the stale rx pair
    for (int p = 0; p < HOLD - 2; p++) period(2, 2, 1);
    check("R7", unlk_oe, 1, "hold restarted by late fault");
    period(2, 2, 1);
    check("R7", unlk_oe, 0, "released after restarted hold");

    period(110, 4, 0);                     // standby with huge tx error
    check("R9", unlk_oe, 0, "standby lane raises no unlock");
    check("R9", tx_pd_oe, 0, "standby tx drive off");

    for (int p = 0; p < 300; p++)
      period(rand_off(), rand_off(), $urandom_range(0, 4) != 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule